// File: doc/BRIEF.md
# Protected Dual-Alarm Interval Timer

This block is a free-running timer peripheral. Its counters run on a slow timer clock, and software configures it through a simple register port on a faster bus clock. An 8-bit sub-second counter advances on every timer tick while the timer runs, and its carry advances a 32-bit seconds counter. Two alarms can raise a level interrupt. The long alarm fires when the seconds count reaches a 20-bit match value. The short alarm is a reloading down-counter of sub-second ticks.

All configuration and counter state lives in the timer domain. Every register write is accepted in the bus domain only while no earlier write is in flight. The write is held stable and handed across with a toggle request. A busy bit stays high until the toggle acknowledge has returned through a synchronizer. The run bit and both counters are write-protected behind an unlock bit. Flags are cleared by writing 0 to them. In synchronous read mode, the counter view freezes while busy is high. In asynchronous read mode, software sees the live synchronized count and need not wait for busy to clear; this mode is meant only for a bus clock more than twice the timer clock.

Register addresses: 0 control, 1 seconds, 2 sub-second, 3 long alarm, 4 short alarm. Reads of addresses 3 to 7 return 0.

Top module: `ivt_timer`

## Requirements
- R1: After reset the control register reads 0x8000, with bit 15 a constant 1 and all other bits 0. Both counters read 0 and `irq` is 0.
- R2: Control bit 6 is the unlock bit. The run bit (bit 0) and writes to the seconds and sub-second registers take effect only if unlock was already 1 when the write arrives in the timer domain. Otherwise they are ignored.
- R3: Control bit 7 (busy, read-only) goes to 1 in the cycle after a write is accepted. It returns to 0 only after the timer domain has acknowledged that write. A write presented while busy is 1 is dropped.
- R4: While running, the sub-second counter increments once per timer clock. Its wrap from 0xFF to 0x00 increments the seconds counter by one.
- R5: The long alarm (address 3) keeps only the low 20 bits written. When a sub-second wrap brings the seconds counter to a value whose low 20 bits equal the alarm, long flag bit 3 is set.
- R6: A write to the short alarm (address 4) also loads its down-counter. While running, the counter decrements each tick. When it is at 0, it sets short flag bit 4 and reloads, giving a period of value+1 ticks.
- R7: A control write of 0 to a flag bit clears it, and a write of 1 leaves it unchanged.
- R8: `irq` is 1 exactly when (long flag AND long enable, bit 1) OR (short flag AND short enable, bit 2).
- R9: With control bit 5 at 0, the seconds and sub-second reads hold their value while busy is 1. With bit 5 at 1, they follow the live count during busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| tclk | input | 1 | Timer clock (slow) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, one bus cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Interrupt, timer clock domain |

## Verification
The counter is exercised from three starting points: a stopped load just below a seconds boundary, a run through a 0xFF wrap, and a long alarm write with junk in its upper 12 bits. Together these separate carry logic, compare width and match timing. The short alarm is run with a reload value far longer than the run window and then with one much shorter, which distinguishes a working reload period from a flag that never or always fires. Protected writes are issued with and without unlock, and back-to-back writes show whether the second is dropped. Paired reads spaced inside a busy window tell the frozen view from the live one.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int ADDR_W = 3;
  localparam int CTL_W  = 7;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_SEC  = 3'd1,
    REG_SUB  = 3'd2,
    REG_LALM = 3'd3,
    REG_SALM = 3'd4
  } reg_sel_e;

  localparam int B_RUN = 0;
  localparam int B_LIE = 1;
  localparam int B_SIE = 2;
  localparam int B_LFL = 3;
  localparam int B_SFL = 4;
  localparam int B_ARD = 5;
  localparam int B_UNL = 6;
  localparam int B_BSY = 7;
  localparam int B_RDY = 15;
endpackage

// File: rtl/ivt_cdc_sync.sv
module ivt_cdc_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/ivt_bus_port.sv
module ivt_bus_port
  import ivt_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              req_tgl,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              ack_tgl,
  input  logic [CTL_W-1:0]  ctrl_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [SUB_W-1:0]  sub_i
);
  localparam int SW = 1 + CTL_W + SEC_W + SUB_W;

  logic [SW-1:0]     snc;
  logic              ack_s;
  logic [CTL_W-1:0]  ctrl_s;
  logic [SEC_W-1:0]  sec_s, view_sec;
  logic [SUB_W-1:0]  sub_s, view_sub;
  logic              req_q, busy;

  ivt_cdc_sync #(.W(SW), .DEPTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ack_tgl, ctrl_i, sec_i, sub_i}),
    .q     (snc)
  );
  assign {ack_s, ctrl_s, sec_s, sub_s} = snc;

  assign busy = req_q ^ ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      req_addr <= '0;
      req_data <= '0;
      view_sec <= '0;
      view_sub <= '0;
    end else begin
      if (wr_en && !busy) begin
        req_q    <= ~req_q;
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
      if (!busy) begin
        view_sec <= sec_s;
        view_sub <= sub_s;
      end
    end
  end

  assign req_tgl = req_q;

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_addr))
      REG_CTRL: begin
        rd_data[CTL_W-1:0] = ctrl_s;
        rd_data[B_BSY]     = busy;
        rd_data[B_RDY]     = 1'b1;
      end
      REG_SEC: rd_data[SEC_W-1:0] = ctrl_s[B_ARD] ? sec_s : view_sec;
      REG_SUB: rd_data[SUB_W-1:0] = ctrl_s[B_ARD] ? sub_s : view_sub;
      default: ;
    endcase
  end

  // R3
  drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> ($stable(req_q) && $stable(req_addr) && $stable(req_data)));
  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> busy);
  // R9
  view_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(view_sec) && $stable(view_sub)));
endmodule

// File: rtl/ivt_core.sv
module ivt_core
  import ivt_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 8,
  parameter int LALM_W = 20,
  parameter int SALM_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              tclk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              ack_tgl,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              irq_o
);
  logic req_s, req_d, strobe;
  logic run, lie, sie, lfl, sfl, ard, unl;
  logic [SEC_W-1:0]  sec, sec_inc;
  logic [SUB_W-1:0]  sub;
  logic [LALM_W-1:0] lalm;
  logic [SALM_W-1:0] salm, scnt;
  logic sub_wrap, long_hit, short_hit;

  ivt_cdc_sync #(.W(1), .DEPTH(2)) u_req_sync (
    .clk   (tclk),
    .rst_n (rst_n),
    .d     (req_tgl),
    .q     (req_s)
  );

  assign strobe    = req_s ^ req_d;
  assign sub_wrap  = run && (sub == {SUB_W{1'b1}});
  assign sec_inc   = sec + SEC_W'(1);
  assign long_hit  = sub_wrap && (sec_inc[LALM_W-1:0] == lalm);
  assign short_hit = run && (scnt == '0);

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= 1'b0; ack_tgl <= 1'b0;
      run <= 1'b0; lie <= 1'b0; sie <= 1'b0; lfl <= 1'b0;
      sfl <= 1'b0; ard <= 1'b0; unl <= 1'b0;
      sec <= '0; sub <= '0; lalm <= '0; salm <= '0; scnt <= '0;
    end else begin
      req_d <= req_s;
      if (run) begin
        sub  <= sub + SUB_W'(1);
        if (sub_wrap) sec <= sec_inc;
        scnt <= short_hit ? salm : scnt - SALM_W'(1);
      end
      lfl <= lfl | long_hit;
      sfl <= sfl | short_hit;
      if (strobe) begin
        ack_tgl <= req_s;
        case (reg_sel_e'(req_addr))
          REG_CTRL: begin
            if (unl) run <= req_data[B_RUN];
            lie <= req_data[B_LIE];
            sie <= req_data[B_SIE];
            lfl <= (lfl & req_data[B_LFL]) | long_hit;
            sfl <= (sfl & req_data[B_SFL]) | short_hit;
            ard <= req_data[B_ARD];
            unl <= req_data[B_UNL];
          end
          REG_SEC:  if (unl) sec <= req_data[SEC_W-1:0];
          REG_SUB:  if (unl) sub <= req_data[SUB_W-1:0];
          REG_LALM: lalm <= req_data[LALM_W-1:0];
          REG_SALM: begin
            salm <= req_data[SALM_W-1:0];
            scnt <= req_data[SALM_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ctrl_o        = '0;
    ctrl_o[B_RUN] = run;
    ctrl_o[B_LIE] = lie;
    ctrl_o[B_SIE] = sie;
    ctrl_o[B_LFL] = lfl;
    ctrl_o[B_SFL] = sfl;
    ctrl_o[B_ARD] = ard;
    ctrl_o[B_UNL] = unl;
  end

  assign sec_o = sec;
  assign sub_o = sub;
  assign irq_o = (lfl & lie) | (sfl & sie);

  // R2
  run_lock_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    !$stable(run) |-> $past(unl));
  // R5
  long_src_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    $rose(lfl) |-> $past(run));
  // R6
  short_src_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    $rose(sfl) |-> $past(run));
  // R4
  carry_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    ($past(run) && ($past(sub) == {SUB_W{1'b1}}) && !$past(strobe))
      |-> (sub == '0 && sec == $past(sec) + SEC_W'(1)));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 8,
  parameter int LALM_W = 20,
  parameter int SALM_W = 32,
  parameter int DATA_W = 32
) (
  input  logic        clk,
  input  logic        tclk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq
);
  logic              req_tgl, ack_tgl;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic [CTL_W-1:0]  ctrl_w;
  logic [SEC_W-1:0]  sec_w;
  logic [SUB_W-1:0]  sub_w;

  ivt_bus_port #(.SEC_W(SEC_W), .SUB_W(SUB_W), .DATA_W(DATA_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .req_tgl  (req_tgl),
    .req_addr (req_addr),
    .req_data (req_data),
    .ack_tgl  (ack_tgl),
    .ctrl_i   (ctrl_w),
    .sec_i    (sec_w),
    .sub_i    (sub_w)
  );

  ivt_core #(.SEC_W(SEC_W), .SUB_W(SUB_W), .LALM_W(LALM_W),
             .SALM_W(SALM_W), .DATA_W(DATA_W)) u_core (
    .tclk     (tclk),
    .rst_n    (rst_n),
    .req_tgl  (req_tgl),
    .req_addr (req_addr),
    .req_data (req_data),
    .ack_tgl  (ack_tgl),
    .ctrl_o   (ctrl_w),
    .sec_o    (sec_w),
    .sub_o    (sub_w),
    .irq_o    (irq)
  );
endmodule

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
  logic        clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always #6 tclk = ~tclk;

  ivt_timer u0 (.clk(clk), .tclk(tclk), .rst_n(rst_n), .wr_en(wr_en),
                .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
                .rd_data(rd_data), .irq(irq));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog got %0d exp done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] ctl(bit run, bit lie, bit sie, bit lfl, bit sfl, bit ard, bit unl);
    return {16'h0000, 1'b1, 8'h00, unl, ard, sfl, lfl, sie, lie, run};
  endfunction

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd0, v);
      if (!v[7]) break;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wait_idle();
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    wait_idle();
  endtask

  task automatic launch(input logic [2:0] a, input logic [31:0] d);
    wait_idle();
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v, v0, v1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'h8000);
    rd(3'd1, v); chk("R1 sec", v, 0);
    rd(3'd2, v); chk("R1 sub", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 protected writes while locked
    wr(3'd1, 32'h1234);
    rd(3'd1, v); chk("R2 sec locked", v, 0);
    wr(3'd0, ctl(1,0,0,0,0,0,0));
    rd(3'd0, v); chk("R2 run locked", v, 32'h8000);
    wr(3'd0, ctl(0,0,0,0,0,0,1));
    rd(3'd0, v); chk("R2 unlock", v, 32'h8040);
    wr(3'd1, 32'h1234); wr(3'd2, 32'hF0);
    rd(3'd1, v); chk("R2 sec unlocked", v, 32'h1234);
    rd(3'd2, v); chk("R2 sub unlocked", v, 32'hF0);

    // R3 busy and dropped back-to-back write
    wait_idle();
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h11;
    @(negedge clk); wr_data = 32'h22;
    @(negedge clk); wr_en = 1'b0; rd_addr = 3'd0; #1 v = rd_data;
    chk("R3 busy set", {31'b0, v[7]}, 1);
    wait_idle();
    rd(3'd0, v); chk("R3 busy clear", {31'b0, v[7]}, 0);
    rd(3'd2, v); chk("R3 second write dropped", v, 32'h11);
    wr(3'd2, 32'hF0);

    // R5 long alarm, upper bits of write ignored
    wr(3'd3, 32'hABC0_1235);
    wr(3'd0, ctl(1,1,0,0,0,0,1));
    repeat (150) @(negedge clk);
    wr(3'd0, ctl(0,1,0,1,1,0,1));
    rd(3'd1, v); chk("R5 sec at alarm", v, 32'h1235);
    rd(3'd0, v); chk("R5 long flag", v, 32'h805A);
    chk("R8 irq long", {31'b0, irq}, 1);

    // R7 flag clear by writing 0
    wr(3'd0, ctl(0,1,0,0,0,0,1));
    rd(3'd0, v); chk("R7 flags cleared", v, 32'h8042);
    chk("R8 irq cleared", {31'b0, irq}, 0);

    // R6 short alarm: long reload does not fire in window
    wr(3'd4, 32'd1000);
    wr(3'd0, ctl(1,1,0,0,0,0,1));
    repeat (100) @(negedge clk);
    wr(3'd0, ctl(0,1,0,1,1,0,1));
    rd(3'd0, v); chk("R6 no early short flag", v, 32'h8042);
    wr(3'd4, 32'd3);
    wr(3'd0, ctl(1,1,1,0,0,0,1));
    repeat (100) @(negedge clk);
    wr(3'd0, ctl(0,1,1,1,1,0,1));
    rd(3'd0, v); chk("R6 short flag", v, 32'h8056);
    chk("R8 irq short", {31'b0, irq}, 1);
    wr(3'd0, ctl(0,1,0,0,1,0,1));
    rd(3'd0, v); chk("R7 flag kept on 1", v, 32'h8052);
    chk("R8 irq masked", {31'b0, irq}, 0);
    wr(3'd0, ctl(0,1,0,0,0,0,1));

    // R4 sub-second wrap carries into seconds
    wr(3'd1, 32'h10); wr(3'd2, 32'hFE);
    rd(3'd2, v); chk("R4 sub load", v, 32'hFE);
    wr(3'd0, ctl(1,1,0,0,0,0,1));
    repeat (30) @(negedge clk);
    wr(3'd0, ctl(0,1,0,0,0,0,1));
    rd(3'd1, v); chk("R4 carry", v, 32'h11);

    // R9 frozen view in sync mode during busy
    wr(3'd0, ctl(1,1,0,0,0,0,1));
    launch(3'd3, 32'h0_1235);
    @(negedge clk); rd_addr = 3'd2; #1 v0 = rd_data;
    repeat (5) @(negedge clk); #1 v1 = rd_data;
    chk("R9 sync frozen", v1, v0);
    wait_idle();

    // R9 live view in async mode during busy
    wr(3'd0, ctl(1,1,0,0,0,1,1));
    launch(3'd3, 32'h0_1235);
    @(negedge clk); rd_addr = 3'd2; #1 v0 = rd_data;
    repeat (5) @(negedge clk); #1 v1 = rd_data;
    chk("R9 async live", {31'b0, (v1 != v0)}, 1);
    wait_idle();
    wr(3'd0, ctl(0,1,0,0,0,0,1));
    rd(3'd0, v); chk("R9 stopped ctrl", v, 32'h8042);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule